// File: doc/BRIEF.md
# Bit-Serial Packet Transmitter

This block takes a 32-bit packet over a parallel valid/ready input and sends it out on one data wire, one bit per clock, least significant bit first. A strobe marks every cycle that carries a packet bit. The packet is made of three fields. A 24-bit payload sits in the low bits, a 6-bit tag comes next, and a 2-bit destination code fills the top two bits. One destination code is reserved. A packet that carries it is taken off the input and is never sent.

Upstream logic hands over packets with the usual handshake. A packet is accepted in any cycle where `in_valid` and `in_ready` are both high. Back-pressure is simple: `in_ready` is low while a packet is on the wire, except during its final bit. This lets the next packet follow with no gap. A repeat request sampled at that same boundary sends the last accepted packet again. The repeat request wins over a waiting new packet, so `in_ready` stays low in that cycle and the new packet must be held.

A parameter picks quiet mode, in which the data wire is held at 0 whenever the strobe is low. Reset aborts any packet in flight and clears the memory of the last packet.

Top module: `bitser_tx`

## Requirements
- R1: Serial bit k, counted from the first strobed cycle of a packet, equals bit k of the packet word {in_addr, in_tag, in_data}. Payload is bits 0..23, tag is bits 24..29 and destination is bits 30..31. A packet is 32 consecutive strobed cycles.
- R2: `ser_valid` is high exactly in the cycles that carry a packet bit. The first bit appears in the cycle after the handshake.
- R3: `in_ready` is high only when no packet is on the wire or the final bit is on the wire, and it is low when a repeat is taken in that cycle.
- R4: With QUIET=1, `ser_data` is 0 in every cycle where `ser_valid` is low.
- R5: While `rst_n` is low, `ser_valid` and `ser_data` are 0. A packet cut short by reset is never resumed.
- R6: A packet accepted during the final bit of the previous one starts in the very next cycle, with no idle cycle between them.
- R7: `resend_req` high at a boundary, with a remembered packet, restarts that packet in full. It takes priority over a new packet.
- R8: A packet whose destination equals FORBID_ADDR (default 2'b11) is consumed by the handshake, is not sent, and does not replace the remembered packet.
- R9: After reset, and until a legal packet is accepted, `resend_req` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream offers a packet |
| in_ready | output | 1 | Block takes the offered packet this cycle |
| in_addr | input | 2 | Destination code of the offered packet |
| in_tag | input | 6 | Tag of the offered packet |
| in_data | input | 24 | Payload of the offered packet |
| resend_req | input | 1 | Request to send the remembered packet again |
| ser_valid | output | 1 | Serial bit strobe |
| ser_data | output | 1 | Serial data bit |

## Verification
Several properties are checked on every cycle. A strobed run always ends exactly after its 32nd bit. `in_ready` only rises at a packet boundary. A legal handshake puts payload bit 0 on the wire in the next cycle. A reserved destination never starts a transfer. In quiet mode the idle data wire stays at 0. Other behaviours need the bench's scenarios, run against a queue-based model. These are the full bit order of the tag and destination fields, the priority of a repeat over a waiting packet, that the remembered packet survives a refused one, and that reset both aborts a transfer and forgets the remembered packet.

// File: rtl/bitser_pkg.sv
package bitser_pkg;
  parameter int ADDR_W = 2;
  parameter int TAG_W  = 6;
  parameter int DATA_W = 24;
  localparam int PKT_W = ADDR_W + TAG_W + DATA_W;
  localparam int CNT_W = $clog2(PKT_W);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [DATA_W-1:0] data_t;

  typedef struct packed {
    addr_t addr;
    tag_t  tag;
    data_t data;
  } pkt_t;
endpackage

// File: rtl/bitser_seq.sv
module bitser_seq
  import bitser_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic addr_ok,
  input  logic resend_req,
  output logic in_ready,
  output logic load_new,
  output logic load_held,
  output logic shift_en,
  output logic busy
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PKT_W - 1);

  logic [CNT_W-1:0] cnt;
  logic             held_ok;
  logic             last_bit;
  logic             boundary;

  assign last_bit  = busy && (cnt == LAST);
  assign boundary  = !busy || last_bit;
  assign load_held = boundary && resend_req && held_ok;
  assign in_ready  = boundary && !load_held;
  assign load_new  = in_ready && in_valid && addr_ok;
  assign shift_en  = busy && !last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      held_ok <= 1'b0;
    end else begin
      if (load_held || load_new) begin
        busy <= 1'b1;
        cnt  <= '0;
        if (load_new) held_ok <= 1'b1;
      end else if (last_bit) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bitser_shift.sv
module bitser_shift
  import bitser_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_new,
  input  logic load_held,
  input  logic shift_en,
  input  pkt_t pkt_in,
  output logic lsb
);
  logic [PKT_W-1:0] shreg;
  logic [PKT_W-1:0] held;

  assign lsb = shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      held  <= '0;
    end else if (load_held) begin
      shreg <= held;
    end else if (load_new) begin
      shreg <= pkt_in;
      held  <= pkt_in;
    end else if (shift_en) begin
      shreg <= {1'b0, shreg[PKT_W-1:1]};
    end
  end
endmodule

// File: rtl/bitser_drive.sv
module bitser_drive #(
  parameter bit QUIET = 1'b0
) (
  input  logic busy,
  input  logic lsb,
  output logic ser_valid,
  output logic ser_data
);
  assign ser_valid = busy;
  generate
    if (QUIET) begin : g_quiet
      assign ser_data = busy & lsb;
    end else begin : g_normal
      assign ser_data = lsb;
    end
  endgenerate
endmodule

// File: rtl/bitser_tx.sv
module bitser_tx
  import bitser_pkg::*;
#(
  parameter bit          QUIET       = 1'b0,
  parameter logic [ADDR_W-1:0] FORBID_ADDR = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DATA_W-1:0] in_data,
  input  logic              resend_req,
  output logic              ser_valid,
  output logic              ser_data
);
  pkt_t pkt_in;
  logic addr_ok, load_new, load_held, shift_en, busy, lsb;

  assign pkt_in  = '{addr: in_addr, tag: in_tag, data: in_data};
  assign addr_ok = (in_addr != FORBID_ADDR);

  bitser_seq u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .addr_ok(addr_ok),
    .resend_req(resend_req), .in_ready(in_ready), .load_new(load_new),
    .load_held(load_held), .shift_en(shift_en), .busy(busy)
  );

  bitser_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load_new(load_new), .load_held(load_held),
    .shift_en(shift_en), .pkt_in(pkt_in), .lsb(lsb)
  );

  bitser_drive #(.QUIET(QUIET)) u_drive (
    .busy(busy), .lsb(lsb), .ser_valid(ser_valid), .ser_data(ser_data)
  );
endmodule

// File: rtl/bitser_tx_chk.sv
module bitser_tx_chk
  import bitser_pkg::*;
#(
  parameter bit                QUIET  = 1'b0,
  parameter logic [ADDR_W-1:0] FORBID = '1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] in_addr,
  input logic              in_data0,
  input logic              ser_valid,
  input logic              ser_data
);
  localparam logic [CNT_W-1:0] LASTPOS = CNT_W'(PKT_W - 1);
  logic [CNT_W-1:0] pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos <= '0;
    else if (ser_valid) pos <= (pos == LASTPOS) ? '0 : pos + 1'b1;
    else pos <= '0;
  end

  // R2: a strobed run only ends after a whole packet
  a_r2_full_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_valid) |-> $past(pos) == LASTPOS);

  // R3: ready only at a packet boundary
  a_r3_ready_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!ser_valid || pos == LASTPOS));

  // R2: legal handshake puts payload bit 0 out next cycle
  a_r2_start_next: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_addr != FORBID) |=>
      (ser_valid && pos == '0 && ser_data == $past(in_data0)));

  // R8: reserved destination never starts a transfer
  a_r8_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_addr == FORBID) |=> !ser_valid);

  // R4: quiet idle wire
  a_r4_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (QUIET && !ser_valid) |-> !ser_data);
endmodule

bind bitser_tx bitser_tx_chk #(.QUIET(QUIET), .FORBID(FORBID_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_addr(in_addr), .in_data0(in_data[0]), .ser_valid(ser_valid),
  .ser_data(ser_data)
);

// File: tb/bitser_tx_tb.sv
module bitser_tx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, resend_req = 1'b0;
  logic [1:0] in_addr = '0;
  logic [5:0] in_tag = '0;
  logic [23:0] in_data = '0;
  logic in_ready, ser_valid, ser_data;

  int checks = 0, errors = 0;
  bit exp_q[$];
  logic [31:0] held = '0;
  bit held_ok = 0;
  bit exp_ready;

  always #5 clk = ~clk;

  bitser_tx #(.QUIET(1'b1), .FORBID_ADDR(2'b11)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_tag(in_tag), .in_data(in_data),
    .resend_req(resend_req), .ser_valid(ser_valid), .ser_data(ser_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_out();
    bit ev, ed;
    ev = (exp_q.size() > 0);
    ed = ev ? exp_q[0] : 1'b0;
    check(ser_valid == ev, "R2 strobe", ser_valid, ev);
    if (ev) check(ser_data == ed, "R1 data bit", ser_data, ed);
    else    check(ser_data == 1'b0, "R4 quiet idle", ser_data, 0);
  endtask

  task automatic cyc(input bit v, input logic [1:0] a, input logic [5:0] t,
                     input logic [23:0] d, input bit rs, output bit acc);
    bit bnd;
    logic [31:0] pkt;
    in_valid = v; in_addr = a; in_tag = t; in_data = d; resend_req = rs;
    bnd = (exp_q.size() <= 1);
    exp_ready = bnd && !(rs && held_ok);
    #1;
    check(in_ready == exp_ready, "R3 ready", in_ready, exp_ready);
    acc = exp_ready && v;
    @(posedge clk);
    pkt = {a, t, d};
    if (exp_q.size() > 0) void'(exp_q.pop_front());
    if (bnd && rs && held_ok) begin
      for (int i = 0; i < 32; i++) exp_q.push_back(held[i]);
    end else if (bnd && v && a != 2'b11) begin
      for (int i = 0; i < 32; i++) exp_q.push_back(pkt[i]);
      held = pkt; held_ok = 1;
    end
    @(negedge clk);
    check_out();
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) cyc(0, 2'b00, 6'h0, 24'h0, 0, acc);
  endtask

  task automatic push_pkt(input logic [1:0] a, input logic [5:0] t, input logic [23:0] d);
    bit acc = 0;
    while (!acc) cyc(1, a, t, d, 0, acc);
    in_valid = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; in_valid = 0; resend_req = 0;
    #1;
    check(ser_valid == 0, "R5 valid in reset", ser_valid, 0);
    check(ser_data == 0, "R5 data in reset", ser_data, 0);
    exp_q.delete(); held_ok = 0;
    @(posedge clk); @(negedge clk);
    rst_n = 1;
    check_out();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit acc;
    @(negedge clk);
    do_reset();
    check(in_ready == 1, "R3 ready after reset", in_ready, 1);

    // R1 R2: single packet with distinct fields
    push_pkt(2'b01, 6'h25, 24'hA5C3F0);
    check(ser_valid == 1, "R2 first bit next cycle", ser_valid, 1);
    idle(40);

    // R6: back-to-back packets
    push_pkt(2'b10, 6'h1A, 24'h0F0F0F);
    push_pkt(2'b00, 6'h3F, 24'h123456);
    check(ser_valid == 1, "R6 no gap", ser_valid, 1);
    idle(40);

    // R7: repeat wins over waiting packet at last bit
    push_pkt(2'b01, 6'h0C, 24'hFEDCBA);
    idle(31);
    cyc(1, 2'b10, 6'h11, 24'h00FF00, 1, acc);
    check(acc == 0, "R7 new packet held back", acc, 0);
    check(ser_valid == 1 && ser_data == 1'b0, "R7 repeat starts", ser_data, 0);
    push_pkt(2'b10, 6'h11, 24'h00FF00);
    idle(40);

    // R8: reserved destination consumed, not sent
    push_pkt(2'b11, 6'h2A, 24'h555555);
    check(ser_valid == 0, "R8 refused", ser_valid, 0);
    idle(5);
    check(ser_valid == 0, "R8 still idle", ser_valid, 0);
    cyc(0, 2'b00, 6'h0, 24'h0, 1, acc);
    check(ser_valid == 1 && ser_data == 1'b0, "R8 remembered packet kept", ser_data, 0);
    idle(40);

    // R5 R9: reset mid-packet, repeat afterwards ignored
    push_pkt(2'b00, 6'h07, 24'h00000F);
    idle(10);
    do_reset();
    idle(5);
    check(ser_valid == 0, "R5 no resume", ser_valid, 0);
    cyc(0, 2'b00, 6'h0, 24'h0, 1, acc);
    check(ser_valid == 0, "R9 repeat ignored", ser_valid, 0);
    idle(5);

    // R8 at the last bit of a busy packet
    push_pkt(2'b10, 6'h30, 24'h800001);
    idle(31);
    cyc(1, 2'b11, 6'h01, 24'hFFFFFF, 0, acc);
    check(acc == 1 && ser_valid == 0, "R8 refused at boundary", ser_valid, 0);
    idle(5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule